// File: doc/BRIEF.md
# Flash Word-Programming Sequencer

This block loads a stream of 32-bit words into a region of on-chip flash. When `start` is pulsed, it first asks the flash to erase the sector that holds the region. It then polls the flash status until the erase has finished and checks that it succeeded. After that it takes words one at a time from an upstream valid/ready source. Before each write it waits until the flash reports idle. It then issues a single-beat write on the data port and holds the request until the flash stops stalling. Finally it reads the status again to learn whether that word was stored.

Addresses run from a first address to a last address, both set by parameters. When the word at the last address is confirmed, `done` pulses for one cycle. A failed erase or a failed word write sends the block into a sticky error state. In that state it reports the failing word address and takes no more words until `clr` or reset. The block, the flash data port and the status port all run on the single clock `clk`. The block never relies on a fixed delay: every wait is a handshake or a status poll.

Top module: `flash_prog_seq`

## Requirements
- R1: While idle, a `start` pulse causes exactly one control-port write: `csr_addr`=1 and `csr_wdata` equal to the sector number in bits [2:0], with the upper bits zero. The block then polls status until it reads idle. If the erase-success bit is clear at that point, the block enters the error state with `err_addr` equal to the first address and takes no word.
- R2: The status register is read at `csr_addr`=0 and its value arrives on `csr_rdata` one cycle after `csr_read`. Its fields are: bits [1:0] busy (00 means idle, any other value means busy), bit 2 erase-success, and bit 3 write-success.
- R3: After accepting a word, the block does not assert `fl_write` until a status read has returned idle.
- R4: `fl_write` stays high with stable `fl_addr` and `fl_wdata` for as long as `fl_waitreq` is high. It drops in the cycle after the first cycle in which `fl_waitreq` is low.
- R5: Every write has `fl_burst`=1 and carries the accepted upstream word unchanged on `fl_wdata`.
- R6: The first write goes to the first address. Each accepted write (a cycle with `fl_write` high and `fl_waitreq` low) moves the next write address up by one.
- R7: After each write, status is polled until idle. If the write-success bit is then clear, the block enters the error state with `err_addr` equal to the address of that word.
- R8: `in_ready` is high only while the block waits for the next word. No word is taken during erase, during a status check, during a write, in the error state, or before `start`.
- R9: Reset and `clr` both leave the block idle with `err` low. Once `err` is set, it stays high until `clr`.
- R10: `done` pulses for exactly one cycle after the word at the last address passes its check, and then the block is idle.
- R11: Correct results do not depend on how long `fl_waitreq` stays high. Stalls of hundreds of cycles still give the same written data and addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the flash ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin erase and programming run |
| clr | input | 1 | Leave the error state |
| in_valid | input | 1 | Upstream word available |
| in_ready | output | 1 | Block takes the word this cycle |
| in_data | input | 32 | Upstream word |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | 32 | Flash write data |
| fl_write | output | 1 | Flash write request |
| fl_burst | output | 4 | Burst count, always 1 |
| fl_waitreq | input | 1 | Flash stall |
| csr_addr | output | 1 | 0 = status, 1 = control |
| csr_read | output | 1 | Status read strobe |
| csr_write | output | 1 | Control write strobe |
| csr_wdata | output | 32 | Control write data |
| csr_rdata | input | 4 | Status bits [3:0] |
| done | output | 1 | Run finished without error |
| err | output | 1 | Sticky error flag |
| err_addr | output | AW | Address of the failing word |

## Verification
The bench builds the block with an 8-bit address and a four-word region from 0x10 to 0x13, with sector number 3. This keeps a whole run short, so one loop can cover normal completion and failures on the first and on the last word. It also covers a failed erase, busy status before and after writes, and stalls of up to 300 cycles. The small region means the final-address compare and the `done` pulse are reached in every passing run.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int STAT_W = 4;
  localparam int BURST_W = 4;
  localparam logic CSR_STATUS = 1'b0;
  localparam logic CSR_CTRL = 1'b1;

  typedef enum logic [3:0] {
    S_IDLE, S_ER_CMD, S_ER_RD, S_ER_WT, S_GET,
    S_PRE_RD, S_PRE_WT, S_WRITE, S_POST_RD, S_POST_WT,
    S_DONE, S_ERR
  } state_t;

  function automatic logic stat_is_idle(input logic [STAT_W-1:0] s);
    return s[1:0] == 2'b00;
  endfunction

  function automatic logic stat_erase_ok(input logic [STAT_W-1:0] s);
    return s[2];
  endfunction

  function automatic logic stat_write_ok(input logic [STAT_W-1:0] s);
    return s[3];
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [2:0] sector);
    return {29'd0, sector};
  endfunction
endpackage

// File: rtl/fps_status_dec.sv
module fps_status_dec
  import fps_pkg::*;
(
  input  logic [STAT_W-1:0] stat,
  output logic              idle,
  output logic              erase_ok,
  output logic              write_ok
);
  assign idle     = stat_is_idle(stat);
  assign erase_ok = stat_erase_ok(stat);
  assign write_ok = stat_write_ok(stat);
endmodule

// File: rtl/fps_addr_ctr.sv
module fps_addr_ctr #(
  parameter int AW = 16,
  parameter logic [AW-1:0] FIRST = '0,
  parameter logic [AW-1:0] LAST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] prev,
  output logic          past_last
);
  localparam logic [AW-1:0] STOP = LAST + {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a);
    return a + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= FIRST;
      prev <= FIRST;
    end else if (load) begin
      addr <= FIRST;
      prev <= FIRST;
    end else if (step) begin
      prev <= addr;
      addr <= bump(addr);
    end
  end

  assign past_last = (addr == STOP);

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> addr == $past(addr) + 1'b1);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] START_ADDR = '0,
  parameter logic [AW-1:0] END_ADDR = 16'h00FF,
  parameter logic [2:0] SECTOR_ID = 3'd3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                clr,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [31:0]         in_data,
  output logic [AW-1:0]       fl_addr,
  output logic [31:0]         fl_wdata,
  output logic                fl_write,
  output logic [BURST_W-1:0]  fl_burst,
  input  logic                fl_waitreq,
  output logic                csr_addr,
  output logic                csr_read,
  output logic                csr_write,
  output logic [31:0]         csr_wdata,
  input  logic [STAT_W-1:0]   csr_rdata,
  output logic                done,
  output logic                err,
  output logic [AW-1:0]       err_addr
);
  state_t state, nxt;
  logic [31:0] wdata_q;
  logic [AW-1:0] err_addr_q, nxt_err_addr;
  logic st_idle, st_erase_ok, st_write_ok;
  logic load_addr, word_taken, write_accept;
  logic [AW-1:0] cur_addr, prev_addr;
  logic at_end;

  fps_status_dec u_dec (
    .stat(csr_rdata), .idle(st_idle), .erase_ok(st_erase_ok), .write_ok(st_write_ok)
  );

  fps_addr_ctr #(.AW(AW), .FIRST(START_ADDR), .LAST(END_ADDR)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load_addr), .step(write_accept),
    .addr(cur_addr), .prev(prev_addr), .past_last(at_end)
  );

  assign load_addr    = (state == S_IDLE) && start;
  assign word_taken   = (state == S_GET) && in_valid;
  assign write_accept = (state == S_WRITE) && !fl_waitreq;

  always_comb begin
    nxt = state;
    nxt_err_addr = err_addr_q;
    unique case (state)
      S_IDLE:    if (start) nxt = S_ER_CMD;
      S_ER_CMD:  nxt = S_ER_RD;
      S_ER_RD:   nxt = S_ER_WT;
      S_ER_WT: begin
        if (!st_idle) nxt = S_ER_RD;
        else if (st_erase_ok) nxt = S_GET;
        else begin
          nxt = S_ERR;
          nxt_err_addr = START_ADDR;
        end
      end
      S_GET:     if (in_valid) nxt = S_PRE_RD;
      S_PRE_RD:  nxt = S_PRE_WT;
      S_PRE_WT:  nxt = st_idle ? S_WRITE : S_PRE_RD;
      S_WRITE:   if (!fl_waitreq) nxt = S_POST_RD;
      S_POST_RD: nxt = S_POST_WT;
      S_POST_WT: begin
        if (!st_idle) nxt = S_POST_RD;
        else if (!st_write_ok) begin
          nxt = S_ERR;
          nxt_err_addr = prev_addr;
        end else if (at_end) nxt = S_DONE;
        else nxt = S_GET;
      end
      S_DONE:    nxt = S_IDLE;
      S_ERR:     if (clr) nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      wdata_q    <= '0;
      err_addr_q <= '0;
    end else begin
      state      <= nxt;
      err_addr_q <= nxt_err_addr;
      if (word_taken) wdata_q <= in_data;
    end
  end

  assign in_ready  = (state == S_GET);
  assign fl_addr   = cur_addr;
  assign fl_wdata  = wdata_q;
  assign fl_write  = (state == S_WRITE);
  assign fl_burst  = BURST_W'(1);
  assign csr_write = (state == S_ER_CMD);
  assign csr_read  = (state == S_ER_RD) || (state == S_PRE_RD) || (state == S_POST_RD);
  assign csr_addr  = csr_write ? CSR_CTRL : CSR_STATUS;
  assign csr_wdata = ctrl_word(SECTOR_ID);
  assign done      = (state == S_DONE);
  assign err       = (state == S_ERR);
  assign err_addr  = err_addr_q;

  assert_write_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_write && fl_waitreq |=> fl_write && $stable(fl_addr) && $stable(fl_wdata));
  assert_write_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_write && !fl_waitreq |=> !fl_write);
  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fl_write && !fl_waitreq |=> fl_addr == $past(fl_addr) + 1'b1);
  assert_idle_before_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_write) |-> $past(st_idle));
  assert_ready_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !fl_write && !csr_read && !csr_write && !err);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clr |=> err && $stable(err_addr));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !in_ready);
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_write, csr_read, csr_write}));
endmodule

// File: tb/tb_flash_prog_seq.sv
module tb_flash_prog_seq;
  localparam int AW = 8;
  localparam logic [7:0] ST = 8'h10;
  localparam logic [7:0] EN = 8'h13;

  typedef struct packed {
    logic [15:0] wait_c;
    logic [7:0]  busy;
    logic [7:0]  pre_busy;
    logic [7:0]  fail_idx;
    logic        erase_fail;
    logic        exp_err;
    logic [7:0]  exp_writes;
    logic [7:0]  exp_eaddr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{16'd0,   8'd0, 8'd0, 8'hFF, 1'b0, 1'b0, 8'd4, 8'h00},
    '{16'd3,   8'd2, 8'd1, 8'hFF, 1'b0, 1'b0, 8'd4, 8'h00},
    '{16'd300, 8'd1, 8'd0, 8'hFF, 1'b0, 1'b0, 8'd4, 8'h00},
    '{16'd2,   8'd1, 8'd0, 8'd0,  1'b0, 1'b1, 8'd1, 8'h10},
    '{16'd1,   8'd3, 8'd2, 8'd3,  1'b0, 1'b1, 8'd4, 8'h13},
    '{16'd0,   8'd2, 8'd0, 8'hFF, 1'b1, 1'b1, 8'd0, 8'h10}
  };

  logic clk = 1'b0;
  logic rst_n, start, clr, in_valid, in_ready;
  logic [31:0] in_data;
  logic [AW-1:0] fl_addr, err_addr;
  logic [31:0] fl_wdata, csr_wdata;
  logic fl_write, fl_waitreq, csr_addr, csr_read, csr_write, done, err;
  logic [3:0] fl_burst;
  logic [3:0] csr_rdata;

  always #10 clk = ~clk;

  flash_prog_seq #(.AW(AW), .START_ADDR(ST), .END_ADDR(EN), .SECTOR_ID(3'd3)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clr(clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_write(fl_write), .fl_burst(fl_burst),
    .fl_waitreq(fl_waitreq), .csr_addr(csr_addr), .csr_read(csr_read),
    .csr_write(csr_write), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .done(done), .err(err), .err_addr(err_addr)
  );

  int wait_c, busy_cfg, pre_cfg, fail_cfg;
  logic erase_fail_cfg, clear_log;
  logic [31:0] base;
  int hold_cnt, busy_left, wr_cnt, src_idx, ctrl_cnt, done_cnt;
  logic wr_ok, prev_acc, prev_wr;
  logic [7:0] prev_a;
  logic [31:0] prev_d;
  logic bad_hold, bad_busy, bad_ready, bad_burst, bad_stable, bad_ctrl;
  logic [7:0] log_addr [8];
  logic [31:0] log_data [8];

  wire accept = fl_write && !fl_waitreq;
  assign fl_waitreq = fl_write && (hold_cnt < wait_c);
  assign in_data = base + 32'(src_idx);

  always @(posedge clk) begin
    if (clear_log) begin
      hold_cnt <= 0; busy_left <= 0; wr_cnt <= 0; src_idx <= 0;
      ctrl_cnt <= 0; done_cnt <= 0; wr_ok <= 1'b0; prev_acc <= 1'b0;
      prev_wr <= 1'b0; bad_hold <= 1'b0; bad_busy <= 1'b0; bad_ready <= 1'b0;
      bad_burst <= 1'b0; bad_stable <= 1'b0; bad_ctrl <= 1'b0; csr_rdata <= 4'h0;
    end else begin
      if (fl_write) hold_cnt <= accept ? 0 : hold_cnt + 1;
      if (accept) begin
        if (wr_cnt < 8) begin
          log_addr[wr_cnt] <= fl_addr;
          log_data[wr_cnt] <= fl_wdata;
        end
        wr_ok <= (wr_cnt != fail_cfg);
        wr_cnt <= wr_cnt + 1;
        busy_left <= busy_cfg;
      end
      if (prev_acc && fl_write) bad_hold <= 1'b1;
      if (fl_write && !prev_wr && busy_left > 0) bad_busy <= 1'b1;
      if (fl_write && prev_wr && !prev_acc && (fl_addr != prev_a || fl_wdata != prev_d))
        bad_stable <= 1'b1;
      if (fl_write && fl_burst != 4'd1) bad_burst <= 1'b1;
      if (in_valid && in_ready) begin
        if (src_idx != wr_cnt) bad_ready <= 1'b1;
        src_idx <= src_idx + 1;
        if (pre_cfg > 0) busy_left <= pre_cfg;
      end
      if (csr_write) begin
        ctrl_cnt <= ctrl_cnt + 1;
        if (csr_addr != 1'b1 || csr_wdata != 32'd3) bad_ctrl <= 1'b1;
        busy_left <= busy_cfg;
      end
      if (csr_read) begin
        if (csr_addr != 1'b0) bad_ctrl <= 1'b1;
        if (busy_left > 0) begin
          csr_rdata <= busy_left[0] ? 4'b0001 : 4'b0010;
          busy_left <= busy_left - 1;
        end else begin
          csr_rdata <= {wr_ok, !erase_fail_cfg, 2'b00};
        end
      end
      if (done) done_cnt <= done_cnt + 1;
      prev_acc <= accept;
      prev_wr <= fl_write;
      prev_a <= fl_addr;
      prev_d <= fl_wdata;
    end
  end

  int n_tests = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    int guard;
    int src_before;
    bit data_ok;
    v = VEC[i];
    wait_c = int'(v.wait_c); busy_cfg = int'(v.busy); pre_cfg = int'(v.pre_busy);
    fail_cfg = (v.fail_idx == 8'hFF) ? 999 : int'(v.fail_idx);
    erase_fail_cfg = v.erase_fail;
    base = 32'hC000_0000 | (32'(i) << 16);
    in_valid = 1'b1;
    @(negedge clk); clear_log = 1'b1;
    @(negedge clk); clear_log = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (done_cnt == 0 && !err && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
    chk(guard < 20000, "R11", $sformatf("vec %0d finished", i), guard, 0);
    chk(err == v.exp_err, v.exp_err ? "R7" : "R10", $sformatf("vec %0d err", i), err, v.exp_err);
    chk(done_cnt == (v.exp_err ? 0 : 1), "R10", $sformatf("vec %0d done pulses", i), done_cnt, v.exp_err ? 0 : 1);
    chk(wr_cnt == int'(v.exp_writes), "R6", $sformatf("vec %0d writes", i), wr_cnt, v.exp_writes);
    data_ok = 1'b1;
    for (int k = 0; k < int'(v.exp_writes) && k < wr_cnt; k++)
      if (log_addr[k] != ST + 8'(k) || log_data[k] != base + 32'(k)) data_ok = 1'b0;
    chk(data_ok, "R5", $sformatf("vec %0d addr/data seq", i), data_ok, 1);
    chk(!bad_burst, "R5", "burst count", bad_burst, 0);
    chk(!bad_hold && !bad_stable, "R4", $sformatf("vec %0d strobe hold/release", i), {bad_hold, bad_stable}, 0);
    chk(!bad_busy, "R3", $sformatf("vec %0d write while busy", i), bad_busy, 0);
    chk(!bad_ready, "R8", $sformatf("vec %0d word taken early", i), bad_ready, 0);
    chk(ctrl_cnt == 1 && !bad_ctrl, "R1", $sformatf("vec %0d erase command", i), ctrl_cnt, 1);
    if (v.exp_err) begin
      chk(err_addr == v.exp_eaddr, v.erase_fail ? "R1" : "R7",
          $sformatf("vec %0d err_addr", i), err_addr, v.exp_eaddr);
      src_before = src_idx;
      repeat (12) @(negedge clk);
      chk(err == 1'b1, "R9", "error sticky", err, 1);
      chk(src_idx == src_before && !in_ready, "R8", "no word in error", src_idx, src_before);
      clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      chk(err == 1'b0 && !in_ready, "R9", "clr leaves error", err, 0);
    end else begin
      chk(!in_ready && !fl_write && !err, "R10", "idle after done", in_ready, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; clr = 1'b0; in_valid = 1'b1; clear_log = 1'b1;
    wait_c = 0; busy_cfg = 0; pre_cfg = 0; fail_cfg = 999; erase_fail_cfg = 1'b0;
    base = 32'h0;
    repeat (3) @(negedge clk);
    chk(!in_ready && !fl_write && !csr_read && !csr_write, "R9", "reset outputs quiet",
        {in_ready, fl_write, csr_read, csr_write}, 0);
    chk(!err && !done, "R9", "reset flags", {err, done}, 0);
    rst_n = 1'b1;
    @(negedge clk); clear_log = 1'b0;
    repeat (5) @(negedge clk);
    chk(!in_ready && src_idx == 0, "R8", "no word before start", src_idx, 0);
    for (int i = 0; i < NV; i++) run_vec(i);
    // R9: reset during a run returns to idle
    wait_c = 50; busy_cfg = 0; pre_cfg = 0; fail_cfg = 999; erase_fail_cfg = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!fl_write && !err && !in_ready, "R9", "reset mid-run", fl_write, 0);
    rst_n = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R11 watchdog: actual %0d expected %0d", 190000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule